// File: doc/BRIEF.md
# Out-of-Order Instruction Issue Window

This block sits between instruction decode and the execute stage. Decode hands it up to two decoded instructions per cycle. Each one is placed in a free slot of a small window. A slot holds four things: the functional-unit class the instruction needs, two source tags each with a ready flag, and a destination tag. Once an instruction is in the window, it waits there until it can be dispatched to its unit. The block applies back-pressure to the front end when it cannot take in a further pair of instructions.

Every cycle, each functional unit that reports itself free receives at most one instruction. The chosen instruction is the oldest entry whose class matches that unit and whose sources are both ready. A blocked older instruction therefore does not hold back a younger one that is independent of it. Entries leave the window in dependency and unit-availability order, not in arrival order. Completed results are announced on broadcast ports as destination tags. Any waiting source that matches such a tag becomes ready.

Age is kept as a compact per-entry rank: 0 is the oldest entry, and ranks count upward in arrival order. When older entries leave, the ranks of the entries behind them close up.

Top module: `instruction_window`

## Requirements
- R1: After reset the window is empty. No issue output is valid, both `in_ready` bits are 1, and `dec_stall` is 0.
- R2: In one cycle, each lane `k` with `in_valid[k]` and `in_ready[k]` high has its instruction written into a free slot. An instruction written at a clock edge can issue in the cycle that follows that edge. Lane 0 is older than lane 1.
- R3: `dec_stall` is 1 whenever fewer than two slots are free. When no slot is free, `in_ready` is `2'b00` and nothing is accepted.
- R4: When exactly one slot is free and both lanes are valid, `in_ready` is `2'b01`. Only the lane 0 instruction is taken, and lane 1 must be presented again.
- R5: `iss_valid[u]` is 1 only when `unit_free[u]` is 1 and some entry has class value `u` and both sources ready. At most one entry issues per unit per cycle. An issued entry leaves the window and never issues again.
- R6: A younger entry whose sources are ready issues ahead of an older entry of the same class whose source is not ready.
- R7: Among several ready entries of the same class, the entry that arrived first issues first. Lane 0 of a pair counts as arriving before lane 1.
- R8: A tag on a valid broadcast lane sets every matching source-ready flag at the next edge. The entry can issue in the cycle after the broadcast. An instruction arriving in the same cycle as a matching broadcast is stored with that source already ready.
- R9: A slot freed by an issue can accept a new instruction in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 2 | Lane valid from decode (lane 0 older) |
| in_ready | output | 2 | Lane accepted this cycle when valid |
| in_cls | input | 2x2 | Unit class per lane (value u selects unit u, 0..2) |
| in_src0 | input | 2x5 | First source tag per lane |
| in_src0_rdy | input | 2 | First source already available |
| in_src1 | input | 2x5 | Second source tag per lane |
| in_src1_rdy | input | 2 | Second source already available |
| in_dst | input | 2x5 | Destination tag per lane |
| dec_stall | output | 1 | Front-end hold: fewer than two free slots |
| bc_valid | input | 2 | Result broadcast lane valid |
| bc_tag | input | 2x5 | Broadcast destination tags |
| unit_free | input | 3 | Functional unit u can accept an instruction |
| iss_valid | output | 3 | Instruction dispatched to unit u this cycle |
| iss_dst | output | 3x5 | Destination tag of the dispatched instruction |

## Verification
The interesting overlaps happen inside a single cycle. A broadcast can wake an entry in the same cycle that decode writes a new instruction naming the broadcast tag as a source. An issue can empty a slot in the same cycle that the full-window back-pressure is observed. The bench creates both overlaps on purpose. It drives a broadcast alongside an insert, and it releases one unit for a single cycle while the window is full and then presents a new instruction right away. A scoreboard, kept separately for each unit, judges the outcome by the order of destination tags on the issue ports. Every check of `in_ready` and `dec_stall` is sampled in the middle of a cycle.

// File: rtl/iw_pkg.sv
package iw_pkg;
    parameter int DEPTH  = 8;
    parameter int UNITS  = 3;
    parameter int TAG_W  = 5;
    parameter int LANES  = 2;
    parameter int BCAST  = 2;
    localparam int IDX_W = $clog2(DEPTH);
    localparam int CLS_W = $clog2(UNITS);
    localparam int CNT_W = $clog2(DEPTH + 1);

    typedef struct packed {
        logic             vld;
        logic [CLS_W-1:0] cls;
        logic [TAG_W-1:0] s0;
        logic             r0;
        logic [TAG_W-1:0] s1;
        logic             r1;
        logic [TAG_W-1:0] dst;
        logic [IDX_W-1:0] rank;
    } iw_entry_t;

    typedef struct packed {
        iw_entry_t [DEPTH-1:0] ent;
        logic [CNT_W-1:0]      count;
    } iw_state_t;
endpackage

// File: rtl/iw_free_find.sv
module iw_free_find #(
    parameter int N  = 8,
    parameter int IW = 3
) (
    input  logic [N-1:0]  busy,
    output logic          found0,
    output logic          found1,
    output logic [IW-1:0] idx0,
    output logic [IW-1:0] idx1
);
    // lowest and second-lowest empty slot
    always_comb begin
        found0 = 1'b0;
        found1 = 1'b0;
        idx0   = '0;
        idx1   = '0;
        for (int i = 0; i < N; i++) begin
            if (!busy[i]) begin
                if (!found0) begin
                    found0 = 1'b1;
                    idx0   = IW'(i);
                end else if (!found1) begin
                    found1 = 1'b1;
                    idx1   = IW'(i);
                end
            end
        end
    end
endmodule

// File: rtl/iw_oldest_pick.sv
module iw_oldest_pick #(
    parameter int N  = 8,
    parameter int IW = 3
) (
    input  logic [N-1:0]         cand,
    input  logic [N-1:0][IW-1:0] rank,
    output logic                 found,
    output logic [IW-1:0]        idx
);
    logic [IW-1:0] best;

    always_comb begin
        found = 1'b0;
        idx   = '0;
        best  = '0;
        for (int i = 0; i < N; i++) begin
            if (cand[i] && (!found || rank[i] < best)) begin
                found = 1'b1;
                idx   = IW'(i);
                best  = rank[i];
            end
        end
    end
endmodule

// File: rtl/iw_wake.sv
module iw_wake #(
    parameter int TW = 5,
    parameter int NB = 2
) (
    input  logic [TW-1:0]         tag,
    input  logic [NB-1:0]         bc_vld,
    input  logic [NB-1:0][TW-1:0] bc_tag,
    output logic                  hit
);
    always_comb begin
        hit = 1'b0;
        for (int b = 0; b < NB; b++) begin
            if (bc_vld[b] && bc_tag[b] == tag) hit = 1'b1;
        end
    end
endmodule

// File: rtl/instruction_window.sv
module instruction_window
    import iw_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [LANES-1:0]            in_valid,
    output logic [LANES-1:0]            in_ready,
    input  logic [LANES-1:0][CLS_W-1:0] in_cls,
    input  logic [LANES-1:0][TAG_W-1:0] in_src0,
    input  logic [LANES-1:0]            in_src0_rdy,
    input  logic [LANES-1:0][TAG_W-1:0] in_src1,
    input  logic [LANES-1:0]            in_src1_rdy,
    input  logic [LANES-1:0][TAG_W-1:0] in_dst,
    output logic                        dec_stall,
    input  logic [BCAST-1:0]            bc_valid,
    input  logic [BCAST-1:0][TAG_W-1:0] bc_tag,
    input  logic [UNITS-1:0]            unit_free,
    output logic [UNITS-1:0]            iss_valid,
    output logic [UNITS-1:0][TAG_W-1:0] iss_dst
);
    iw_state_t st_q, st_d;

    logic [DEPTH-1:0]            busy;
    logic [DEPTH-1:0][IDX_W-1:0] rank_v;
    logic [DEPTH-1:0]            hit0, hit1;
    logic [LANES-1:0]            lhit0, lhit1;
    logic                        f0, f1;
    logic [IDX_W-1:0]            i0, i1;
    logic [IDX_W-1:0]            slot_a, slot_b;
    logic                        take0, take1;
    logic [UNITS-1:0][DEPTH-1:0] cand;
    logic [UNITS-1:0]            pick_found;
    logic [UNITS-1:0][IDX_W-1:0] pick_idx;
    logic [DEPTH-1:0]            iss_mask;
    logic [CNT_W-1:0]            n_iss, remain;
    logic [IDX_W-1:0]            below;
    logic [CNT_W-1:0]            occ_q;

    assign occ_q = st_q.count;

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            busy[i]   = st_q.ent[i].vld;
            rank_v[i] = st_q.ent[i].rank;
        end
    end

    iw_free_find #(.N(DEPTH), .IW(IDX_W)) u_free (
        .busy(busy), .found0(f0), .found1(f1), .idx0(i0), .idx1(i1)
    );

    // ---- acceptance: lane 0 always before lane 1
    assign in_ready[0] = f0;
    assign in_ready[1] = in_valid[0] ? f1 : f0;
    assign take0       = in_valid[0] & in_ready[0];
    assign take1       = in_valid[1] & in_ready[1];
    assign slot_a      = i0;
    assign slot_b      = in_valid[0] ? i1 : i0;
    assign dec_stall   = ~f1;

    // ---- wakeup comparators for stored and arriving sources
    for (genvar e = 0; e < DEPTH; e++) begin : g_ent_wake
        iw_wake #(.TW(TAG_W), .NB(BCAST)) u_w0 (
            .tag(st_q.ent[e].s0), .bc_vld(bc_valid), .bc_tag(bc_tag), .hit(hit0[e])
        );
        iw_wake #(.TW(TAG_W), .NB(BCAST)) u_w1 (
            .tag(st_q.ent[e].s1), .bc_vld(bc_valid), .bc_tag(bc_tag), .hit(hit1[e])
        );
    end
    for (genvar l = 0; l < LANES; l++) begin : g_lane_wake
        iw_wake #(.TW(TAG_W), .NB(BCAST)) u_w0 (
            .tag(in_src0[l]), .bc_vld(bc_valid), .bc_tag(bc_tag), .hit(lhit0[l])
        );
        iw_wake #(.TW(TAG_W), .NB(BCAST)) u_w1 (
            .tag(in_src1[l]), .bc_vld(bc_valid), .bc_tag(bc_tag), .hit(lhit1[l])
        );
    end

    // ---- per-unit selection of the oldest ready entry
    always_comb begin
        for (int u = 0; u < UNITS; u++) begin
            for (int i = 0; i < DEPTH; i++) begin
                cand[u][i] = st_q.ent[i].vld && st_q.ent[i].r0 && st_q.ent[i].r1
                             && (st_q.ent[i].cls == CLS_W'(u));
            end
        end
    end

    for (genvar u = 0; u < UNITS; u++) begin : g_unit
        iw_oldest_pick #(.N(DEPTH), .IW(IDX_W)) u_pick (
            .cand(cand[u]), .rank(rank_v), .found(pick_found[u]), .idx(pick_idx[u])
        );
        assign iss_valid[u] = pick_found[u] & unit_free[u];
        assign iss_dst[u]   = st_q.ent[pick_idx[u]].dst;
    end

    always_comb begin
        iss_mask = '0;
        for (int u = 0; u < UNITS; u++) begin
            if (iss_valid[u]) iss_mask[pick_idx[u]] = 1'b1;
        end
    end

    // ---- next state
    always_comb begin
        st_d  = st_q;
        n_iss = '0;
        below = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (iss_mask[i]) n_iss = n_iss + CNT_W'(1);
        end
        for (int i = 0; i < DEPTH; i++) begin
            below = '0;
            for (int j = 0; j < DEPTH; j++) begin
                if (iss_mask[j] && rank_v[j] < rank_v[i]) below = below + IDX_W'(1);
            end
            st_d.ent[i].rank = rank_v[i] - below;
            st_d.ent[i].r0   = st_q.ent[i].r0 | hit0[i];
            st_d.ent[i].r1   = st_q.ent[i].r1 | hit1[i];
            if (iss_mask[i]) st_d.ent[i].vld = 1'b0;
        end
        remain = st_q.count - n_iss;
        if (take0) begin
            st_d.ent[slot_a].vld  = 1'b1;
            st_d.ent[slot_a].cls  = in_cls[0];
            st_d.ent[slot_a].s0   = in_src0[0];
            st_d.ent[slot_a].r0   = in_src0_rdy[0] | lhit0[0];
            st_d.ent[slot_a].s1   = in_src1[0];
            st_d.ent[slot_a].r1   = in_src1_rdy[0] | lhit1[0];
            st_d.ent[slot_a].dst  = in_dst[0];
            st_d.ent[slot_a].rank = IDX_W'(remain);
        end
        if (take1) begin
            st_d.ent[slot_b].vld  = 1'b1;
            st_d.ent[slot_b].cls  = in_cls[1];
            st_d.ent[slot_b].s0   = in_src0[1];
            st_d.ent[slot_b].r0   = in_src0_rdy[1] | lhit0[1];
            st_d.ent[slot_b].s1   = in_src1[1];
            st_d.ent[slot_b].r1   = in_src1_rdy[1] | lhit1[1];
            st_d.ent[slot_b].dst  = in_dst[1];
            st_d.ent[slot_b].rank = IDX_W'(remain + CNT_W'(take0));
        end
        st_d.count = remain + CNT_W'(take0) + CNT_W'(take1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/iw_checker.sv
module iw_checker
    import iw_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic [LANES-1:0] in_valid,
    input logic [LANES-1:0] in_ready,
    input logic             dec_stall,
    input logic [UNITS-1:0] unit_free,
    input logic [UNITS-1:0] iss_valid,
    input logic [CNT_W-1:0] occ
);
    int acc_n, iss_n;
    assign acc_n = $countones(in_valid & in_ready);
    assign iss_n = $countones(iss_valid);

    p_bounded_r2: assert property (@(posedge clk) disable iff (!rst_n)
        int'(occ) <= DEPTH);

    p_occ_track_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> int'(occ) == int'($past(occ)) + $past(acc_n) - $past(iss_n));

    p_stall_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(occ) >= DEPTH - 1) |-> dec_stall);

    p_full_block_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(occ) == DEPTH) |-> (in_ready == '0));

    p_single_take_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(occ) == DEPTH - 1 && in_valid == 2'b11) |-> (in_ready == 2'b01));

    p_issue_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid & ~unit_free) == '0);
endmodule

bind instruction_window iw_checker u_iw_checker (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .dec_stall(dec_stall), .unit_free(unit_free), .iss_valid(iss_valid), .occ(occ_q)
);

// File: tb/instruction_window_bench.sv
module instruction_window_bench;
    import iw_pkg::*;

    logic                        clk = 1'b0;
    logic                        rst_n = 1'b0;
    logic [LANES-1:0]            in_valid = '0;
    logic [LANES-1:0]            in_ready;
    logic [LANES-1:0][CLS_W-1:0] in_cls = '0;
    logic [LANES-1:0][TAG_W-1:0] in_src0 = '0;
    logic [LANES-1:0]            in_src0_rdy = '0;
    logic [LANES-1:0][TAG_W-1:0] in_src1 = '0;
    logic [LANES-1:0]            in_src1_rdy = '0;
    logic [LANES-1:0][TAG_W-1:0] in_dst = '0;
    logic                        dec_stall;
    logic [BCAST-1:0]            bc_valid = '0;
    logic [BCAST-1:0][TAG_W-1:0] bc_tag = '0;
    logic [UNITS-1:0]            unit_free = '0;
    logic [UNITS-1:0]            iss_valid;
    logic [UNITS-1:0][TAG_W-1:0] iss_dst;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        int tag;
        int req;
    } exp_t;
    exp_t exp_q[UNITS][$];

    always #10 clk = ~clk;   // 50 MHz

    instruction_window u_instruction_window (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_cls(in_cls), .in_src0(in_src0), .in_src0_rdy(in_src0_rdy),
        .in_src1(in_src1), .in_src1_rdy(in_src1_rdy), .in_dst(in_dst),
        .dec_stall(dec_stall), .bc_valid(bc_valid), .bc_tag(bc_tag),
        .unit_free(unit_free), .iss_valid(iss_valid), .iss_dst(iss_dst)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic lane(input int l, input int cls, input int s0, input bit r0,
                        input int s1, input bit r1, input int dst);
        in_valid[l]    = 1'b1;
        in_cls[l]      = CLS_W'(cls);
        in_src0[l]     = TAG_W'(s0);
        in_src0_rdy[l] = r0;
        in_src1[l]     = TAG_W'(s1);
        in_src1_rdy[l] = r1;
        in_dst[l]      = TAG_W'(dst);
    endtask

    task automatic expect_iss(input int u, input int tag, input int req);
        exp_t e;
        e.tag = tag;
        e.req = req;
        exp_q[u].push_back(e);
    endtask

    // advance one cycle; inputs change 2 ns after the edge
    task automatic step();
        @(posedge clk);
        #2;
        in_valid = '0;
        bc_valid = '0;
    endtask

    task automatic mid();
        @(negedge clk);
        #1;
    endtask

    // monitor: compare each dispatch with the per-unit scoreboard
    always @(negedge clk) begin
        if (rst_n && !done) begin
            for (int u = 0; u < UNITS; u++) begin
                if (iss_valid[u]) begin
                    if (!unit_free[u]) begin
                        chk(1'b0, "R5 issue to busy unit", u, -1);
                    end else if (exp_q[u].size() == 0) begin
                        chk(1'b0, "R5 unexpected issue", int'(iss_dst[u]), -1);
                    end else begin
                        exp_t e;
                        e = exp_q[u].pop_front();
                        chk(int'(iss_dst[u]) == e.tag, $sformatf("R%0d issue order unit %0d", e.req, u),
                            int'(iss_dst[u]), e.tag);
                    end
                end
            end
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        chk(1'b0, "watchdog expired", 0, 1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #2;
        rst_n = 1'b1;
        mid();
        // R1 reset state
        chk(iss_valid == '0, "R1 iss_valid", int'(iss_valid), 0);
        chk(in_ready == 2'b11, "R1 in_ready", int'(in_ready), 3);
        chk(dec_stall == 1'b0, "R1 dec_stall", int'(dec_stall), 0);

        // R6/R2: older blocked on tag 1, younger ready, same unit 0
        step();
        lane(0, 0, 1, 1'b0, 0, 1'b1, 10);
        lane(1, 0, 2, 1'b1, 0, 1'b1, 11);
        mid();
        chk(in_ready == 2'b11, "R2 pair accepted", int'(in_ready), 3);
        expect_iss(0, 11, 6);
        expect_iss(0, 10, 8);
        step();
        unit_free[0] = 1'b1;
        repeat (3) step();
        // R8 broadcast tag 1 wakes entry 10
        bc_valid[1] = 1'b1;
        bc_tag[1]   = TAG_W'(1);
        step();
        repeat (2) step();
        // R8 arrival together with its matching broadcast
        lane(0, 0, 7, 1'b0, 0, 1'b1, 12);
        bc_valid[0] = 1'b1;
        bc_tag[0]   = TAG_W'(7);
        expect_iss(0, 12, 8);
        step();
        repeat (3) step();
        chk(exp_q[0].size() == 0, "R8 unit0 drained", exp_q[0].size(), 0);

        // R7: three ready entries for busy unit 1
        lane(0, 1, 0, 1'b1, 0, 1'b1, 13);
        lane(1, 1, 0, 1'b1, 0, 1'b1, 14);
        step();
        lane(0, 1, 0, 1'b1, 0, 1'b1, 15);
        step();
        expect_iss(1, 13, 7);
        expect_iss(1, 14, 7);
        expect_iss(1, 15, 7);
        unit_free[1] = 1'b1;
        repeat (5) step();
        chk(exp_q[1].size() == 0, "R7 unit1 drained", exp_q[1].size(), 0);

        // R3/R4/R9: fill window for busy unit 2
        for (int p = 0; p < 3; p++) begin
            lane(0, 2, 0, 1'b1, 0, 1'b1, 20 + 2 * p);
            lane(1, 2, 0, 1'b1, 0, 1'b1, 21 + 2 * p);
            step();
        end
        mid();
        chk(dec_stall == 1'b0, "R3 two slots free", int'(dec_stall), 0);
        step();
        lane(0, 2, 0, 1'b1, 0, 1'b1, 26);
        step();
        mid();
        chk(dec_stall == 1'b1, "R3 one slot free", int'(dec_stall), 1);
        step();
        lane(0, 2, 0, 1'b1, 0, 1'b1, 27);
        lane(1, 2, 0, 1'b1, 0, 1'b1, 28);
        mid();
        chk(in_ready == 2'b01, "R4 single accept", int'(in_ready), 1);
        step();
        lane(0, 2, 0, 1'b1, 0, 1'b1, 29);
        mid();
        chk(in_ready == 2'b00, "R3 full in_ready", int'(in_ready), 0);
        chk(dec_stall == 1'b1, "R3 full stall", int'(dec_stall), 1);
        step();
        expect_iss(2, 20, 5);
        unit_free[2] = 1'b1;
        step();
        unit_free[2] = 1'b0;
        mid();
        chk(in_ready[0] == 1'b1, "R9 freed slot reusable", int'(in_ready[0]), 1);
        step();
        lane(0, 2, 0, 1'b1, 0, 1'b1, 30);
        step();
        for (int t = 21; t <= 27; t++) expect_iss(2, t, 7);
        expect_iss(2, 30, 9);
        unit_free[2] = 1'b1;
        repeat (12) step();
        for (int u = 0; u < UNITS; u++) begin
            chk(exp_q[u].size() == 0, "R5 scoreboard empty", exp_q[u].size(), 0);
        end
        mid();
        chk(iss_valid == '0, "R5 no reissue", int'(iss_valid), 0);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule